// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Unit

This unit sits on the data side of a memory port and tracks the reservation that a load-linked / store-conditional pair depends on. When the cache side reports that a locked read has finished, the unit records the cache line involved and the identifier of the requester that issued it. Instruction fetches, plain loads and plain stores never create a reservation.

When a store-conditional is presented, the unit compares the query against the held reservation. The comparison uses the line address and the requester identifier. If both match, the reservation is consumed and the store is passed on to the cache. The check and the clear happen on the same clock edge, so no other request can be serviced between them. If they do not match, the unit answers with a dedicated failure code. That code differs from the busy code used elsewhere on the port, and the store is not passed on.

A coherence invalidate or an eviction that names the reserved line removes the reservation. There is a single reservation register, so the most recent locked-read completion from any requester replaces whatever was held before.

Top module: `llsc_resv_unit`

## Requirements
- R1: After reset no reservation is held, so a store-conditional to any line fails. While reset is asserted and on the first cycle after it, `sc_resp_valid` and `st_fwd_valid` are low.
- R2: A completion with `cpl_kind` = 2 (locked read) records the line of `cpl_addr` and the owner `cpl_id`. A later store-conditional to that line from the same owner succeeds: `sc_status` = 0, `st_fwd_valid` = 1, and `st_fwd_addr`/`st_fwd_id` carry the query's full address and identifier.
- R3: A store-conditional to the reserved line from a different identifier fails. The owner's reservation survives that failure.
- R4: A store-conditional to a line other than the reserved one fails.
- R5: A successful store-conditional consumes the reservation. A repeated query to the same line and identifier then fails.
- R6: Addresses are compared per cache line. The low `LINE_OFF_W` bits are ignored in completions, queries and invalidates.
- R7: Completions with `cpl_kind` 0 (load), 1 (instruction fetch) or 3 (plain store) neither create nor disturb a reservation.
- R8: An invalidate whose line equals the reserved line clears the reservation. An invalidate to any other line leaves it intact.
- R9: A new locked-read completion from any requester replaces the single held reservation.
- R10: A failure answers with `sc_status` = -2 in two's complement (3'b110 at the default width) and `st_fwd_valid` = 0. The busy code -1 is never produced.
- R11: A query is judged against the reservation as it stood before the clock edge on which the query is sampled. A locked-read completion on that same edge installs its reservation afterwards. An invalidate on that same edge does not defeat the query.
- R12: Every query sampled at a rising edge gives exactly one `sc_resp_valid` pulse, visible after that edge. No response appears without a query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpl_valid | input | 1 | Completion report valid |
| cpl_kind | input | 2 | Completion type: 0 load, 1 instruction fetch, 2 locked read, 3 store |
| cpl_addr | input | ADDR_W | Completed access address |
| cpl_id | input | ID_W | Requester of the completed access |
| sc_valid | input | 1 | Store-conditional query valid |
| sc_addr | input | ADDR_W | Store-conditional address |
| sc_id | input | ID_W | Store-conditional requester |
| inv_valid | input | 1 | Coherence invalidate or eviction valid |
| inv_addr | input | ADDR_W | Address of the invalidated line |
| sc_resp_valid | output | 1 | Query answer valid, one cycle after the query |
| sc_status | output | STAT_W | 0 on success, -2 on failure |
| st_fwd_valid | output | 1 | Store passed on to the cache |
| st_fwd_addr | output | ADDR_W | Address of the passed-on store |
| st_fwd_id | output | ID_W | Requester of the passed-on store |

## Verification
The properties assume that `cpl_kind` carries only the four listed codes. They also assume that `rst_n` is low from time zero. The consumption property further assumes that the locked-read completion is the only thing that can re-create a reservation between two queries. The stimulus keeps to these assumptions. It changes inputs only on falling edges and holds reset low from the start. It issues at most one query, one completion and one invalidate per cycle. It places same-edge collisions of a query with a completion or an invalidate deliberately, so that the pre-edge judging rule is exercised rather than left to chance.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

   // Completion type codes presented on cpl_kind.
   typedef enum logic [1:0] {
      KIND_LOAD      = 2'd0,
      KIND_IFETCH    = 2'd1,
      KIND_LOCKED_RD = 2'd2,
      KIND_STORE     = 2'd3
   } cpl_kind_e;

   // Answer codes; BUSY belongs to the upstream port and is never produced here.
   localparam int unsigned CODE_OK   = 0;
   localparam int          CODE_BUSY = -1;
   localparam int          CODE_FAIL = -2;

endpackage

// File: rtl/llsc_line_map.sv
module llsc_line_map #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_OFF_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] line
);
   generate
      if (LINE_OFF_W == 0) begin : g_byte_lines
         assign line = addr;
      end else begin : g_masked_lines
         localparam logic [ADDR_W-1:0] OFF_MASK = (ADDR_W'(1) << LINE_OFF_W) - ADDR_W'(1);
         assign line = addr & ~OFF_MASK;
      end
   endgenerate
endmodule

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned ID_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [ADDR_W-1:0] set_line,
   input  logic [ID_W-1:0]   set_id,
   input  logic              clr_en,
   output logic              resv_vld,
   output logic [ADDR_W-1:0] resv_line,
   output logic [ID_W-1:0]   resv_id
);
   // A completion on the same edge as a clear is the later event: it wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resv_vld  <= 1'b0;
         resv_line <= '0;
         resv_id   <= '0;
      end else if (set_en) begin
         resv_vld  <= 1'b1;
         resv_line <= set_line;
         resv_id   <= set_id;
      end else if (clr_en) begin
         resv_vld  <= 1'b0;
      end
   end
endmodule

// File: rtl/llsc_sc_judge.sv
module llsc_sc_judge #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned ID_W   = 4,
   parameter int unsigned STAT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sc_valid,
   input  logic [ADDR_W-1:0] sc_addr,
   input  logic [ADDR_W-1:0] sc_line,
   input  logic [ID_W-1:0]   sc_id,
   input  logic              resv_vld,
   input  logic [ADDR_W-1:0] resv_line,
   input  logic [ID_W-1:0]   resv_id,
   output logic              hit,
   output logic              resp_valid,
   output logic [STAT_W-1:0] status,
   output logic              fwd_valid,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic [ID_W-1:0]   fwd_id
);
   localparam logic [STAT_W-1:0] ST_OK   = STAT_W'(llsc_pkg::CODE_OK);
   localparam logic [STAT_W-1:0] ST_FAIL = {{(STAT_W-1){1'b1}}, 1'b0};

   // Judged on the pre-edge reservation; the clear lands on the same edge.
   assign hit = sc_valid && resv_vld && (sc_line == resv_line) && (sc_id == resv_id);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         status     <= ST_OK;
         fwd_valid  <= 1'b0;
         fwd_addr   <= '0;
         fwd_id     <= '0;
      end else begin
         resp_valid <= sc_valid;
         status     <= (sc_valid && !hit) ? ST_FAIL : ST_OK;
         fwd_valid  <= hit;
         if (hit) begin
            fwd_addr <= sc_addr;
            fwd_id   <= sc_id;
         end
      end
   end
endmodule

// File: rtl/llsc_resv_unit.sv
module llsc_resv_unit #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_OFF_W = 6,
   parameter int unsigned ID_W       = 4,
   parameter int unsigned STAT_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpl_valid,
   input  logic [1:0]        cpl_kind,
   input  logic [ADDR_W-1:0] cpl_addr,
   input  logic [ID_W-1:0]   cpl_id,
   input  logic              sc_valid,
   input  logic [ADDR_W-1:0] sc_addr,
   input  logic [ID_W-1:0]   sc_id,
   input  logic              inv_valid,
   input  logic [ADDR_W-1:0] inv_addr,
   output logic              sc_resp_valid,
   output logic [STAT_W-1:0] sc_status,
   output logic              st_fwd_valid,
   output logic [ADDR_W-1:0] st_fwd_addr,
   output logic [ID_W-1:0]   st_fwd_id
);
   import llsc_pkg::*;

   localparam int unsigned N_PORTS = 3;
   localparam int unsigned P_CPL   = 0;
   localparam int unsigned P_SC    = 1;
   localparam int unsigned P_INV   = 2;

   generate
      if (LINE_OFF_W >= ADDR_W) begin : g_bad_off
         $error("LINE_OFF_W must be below ADDR_W");
      end
      if (STAT_W < 2) begin : g_bad_stat
         $error("STAT_W must hold the value -2");
      end
      if (ID_W < 1) begin : g_bad_id
         $error("ID_W must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] raw_addr [N_PORTS];
   logic [ADDR_W-1:0] line_of  [N_PORTS];

   assign raw_addr[P_CPL] = cpl_addr;
   assign raw_addr[P_SC]  = sc_addr;
   assign raw_addr[P_INV] = inv_addr;

   generate
      for (genvar p = 0; p < N_PORTS; p++) begin : g_map
         llsc_line_map #(.ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W)) u_map (
            .addr (raw_addr[p]),
            .line (line_of[p])
         );
      end
   endgenerate

   logic              resv_vld;
   logic [ADDR_W-1:0] resv_line;
   logic [ID_W-1:0]   resv_id;
   logic              sc_hit;
   logic              set_en;
   logic              inv_hit;

   assign set_en  = cpl_valid && (cpl_kind_e'(cpl_kind) == KIND_LOCKED_RD);
   assign inv_hit = inv_valid && resv_vld && (line_of[P_INV] == resv_line);

   llsc_resv_reg #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_resv (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (set_en),
      .set_line  (line_of[P_CPL]),
      .set_id    (cpl_id),
      .clr_en    (sc_hit || inv_hit),
      .resv_vld  (resv_vld),
      .resv_line (resv_line),
      .resv_id   (resv_id)
   );

   llsc_sc_judge #(.ADDR_W(ADDR_W), .ID_W(ID_W), .STAT_W(STAT_W)) u_judge (
      .clk        (clk),
      .rst_n      (rst_n),
      .sc_valid   (sc_valid),
      .sc_addr    (sc_addr),
      .sc_line    (line_of[P_SC]),
      .sc_id      (sc_id),
      .resv_vld   (resv_vld),
      .resv_line  (resv_line),
      .resv_id    (resv_id),
      .hit        (sc_hit),
      .resp_valid (sc_resp_valid),
      .status     (sc_status),
      .fwd_valid  (st_fwd_valid),
      .fwd_addr   (st_fwd_addr),
      .fwd_id     (st_fwd_id)
   );
endmodule

// File: rtl/llsc_resv_chk.sv
module llsc_resv_chk #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_OFF_W = 6,
   parameter int unsigned ID_W       = 4,
   parameter int unsigned STAT_W     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpl_valid,
   input logic [1:0]        cpl_kind,
   input logic              sc_valid,
   input logic [ADDR_W-1:0] sc_addr,
   input logic [ID_W-1:0]   sc_id,
   input logic              sc_resp_valid,
   input logic [STAT_W-1:0] sc_status,
   input logic              st_fwd_valid,
   input logic [ADDR_W-1:0] st_fwd_addr,
   input logic [ID_W-1:0]   st_fwd_id
);
   localparam logic [STAT_W-1:0] ST_OK   = '0;
   localparam logic [STAT_W-1:0] ST_FAIL = {{(STAT_W-1){1'b1}}, 1'b0};

   a_r1_quiet_in_reset: assert property (@(posedge clk)
      !rst_n |=> (!sc_resp_valid && !st_fwd_valid));

   a_r12_answer_follows_query: assert property (@(posedge clk) disable iff (!rst_n)
      sc_valid |=> sc_resp_valid);

   a_r12_no_unasked_answer: assert property (@(posedge clk) disable iff (!rst_n)
      !sc_valid |=> !sc_resp_valid);

   a_r10_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
      sc_resp_valid |-> (sc_status == ST_OK || sc_status == ST_FAIL));

   a_r10_forward_only_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
      st_fwd_valid |-> (sc_resp_valid && sc_status == ST_OK));

   a_r10_ok_implies_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_resp_valid && sc_status == ST_OK) |-> st_fwd_valid);

   a_r2_forward_matches_query: assert property (@(posedge clk) disable iff (!rst_n)
      sc_valid |=> (!st_fwd_valid || (st_fwd_addr == $past(sc_addr) && st_fwd_id == $past(sc_id))));

   // R5: a success is not repeatable unless a locked read completed in between.
   a_r5_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (st_fwd_valid && sc_valid && $past(sc_valid)
       && ((sc_addr >> LINE_OFF_W) == ($past(sc_addr) >> LINE_OFF_W))
       && (sc_id == $past(sc_id))
       && !($past(cpl_valid) && $past(cpl_kind) == 2'd2)
       && !(cpl_valid && cpl_kind == 2'd2))
      |=> (sc_resp_valid && !st_fwd_valid));
endmodule

bind llsc_resv_unit llsc_resv_chk #(
   .ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W), .ID_W(ID_W), .STAT_W(STAT_W)
) u_chk (.*);

// File: tb/tb_llsc_resv_unit.sv
module tb_llsc_resv_unit;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int IW = 4;
   localparam int SW = 3;
   localparam logic [SW-1:0] ST_FAIL = 3'b110;
   localparam logic [1:0] K_LOAD = 2'd0, K_IFETCH = 2'd1, K_LR = 2'd2, K_STORE = 2'd3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpl_valid = 1'b0;
   logic [1:0]    cpl_kind = '0;
   logic [AW-1:0] cpl_addr = '0;
   logic [IW-1:0] cpl_id = '0;
   logic          sc_valid = 1'b0;
   logic [AW-1:0] sc_addr = '0;
   logic [IW-1:0] sc_id = '0;
   logic          inv_valid = 1'b0;
   logic [AW-1:0] inv_addr = '0;
   logic          sc_resp_valid;
   logic [SW-1:0] sc_status;
   logic          st_fwd_valid;
   logic [AW-1:0] st_fwd_addr;
   logic [IW-1:0] st_fwd_id;

   llsc_resv_unit dut (
      .clk(clk), .rst_n(rst_n),
      .cpl_valid(cpl_valid), .cpl_kind(cpl_kind), .cpl_addr(cpl_addr), .cpl_id(cpl_id),
      .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_id(sc_id),
      .inv_valid(inv_valid), .inv_addr(inv_addr),
      .sc_resp_valid(sc_resp_valid), .sc_status(sc_status),
      .st_fwd_valid(st_fwd_valid), .st_fwd_addr(st_fwd_addr), .st_fwd_id(st_fwd_id)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      bit            ok;
      logic [AW-1:0] addr;
      logic [IW-1:0] id;
      int            cyc;
      string         tag;
   } exp_t;

   exp_t sbq[$];
   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic report(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   // Monitor: pops expected answers as the design produces them.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (st_fwd_valid && !sc_resp_valid)
            report("R10", "forward without answer", 64'(st_fwd_valid), 64'(0));
         if (sc_resp_valid) begin
            if (sbq.size() == 0) begin
               report("R12", "unexpected answer", 64'(1), 64'(0));
            end else begin
               exp_t e;
               e = sbq.pop_front();
               report("R12", "answer cycle", 64'(cyc), 64'(e.cyc + 1));
               report(e.tag, "status", 64'(sc_status), e.ok ? 64'(0) : 64'(ST_FAIL));
               report(e.tag, "forward valid", 64'(st_fwd_valid), 64'(e.ok));
               if (e.ok) begin
                  report(e.tag, "forward addr", 64'(st_fwd_addr), 64'(e.addr));
                  report(e.tag, "forward id", 64'(st_fwd_id), 64'(e.id));
               end
            end
         end else if (sbq.size() != 0 && sbq[0].cyc + 1 < cyc) begin
            exp_t e;
            e = sbq.pop_front();
            report("R12", "missing answer", 64'(0), 64'(1));
         end
      end
   end

   task automatic step(input bit dc, input logic [1:0] k, input logic [AW-1:0] ca, input logic [IW-1:0] ci,
                       input bit ds, input logic [AW-1:0] sa, input logic [IW-1:0] si, input bit eok, input string tag,
                       input bit di, input logic [AW-1:0] ia);
      cpl_valid = dc; cpl_kind = k; cpl_addr = ca; cpl_id = ci;
      sc_valid = ds; sc_addr = sa; sc_id = si;
      inv_valid = di; inv_addr = ia;
      if (ds) sbq.push_back('{ok: eok, addr: sa, id: si, cyc: cyc, tag: tag});
      @(negedge clk);
      cpl_valid = 1'b0; sc_valid = 1'b0; inv_valid = 1'b0;
   endtask

   task automatic cpl(input logic [1:0] k, input logic [AW-1:0] a, input logic [IW-1:0] id);
      step(1'b1, k, a, id, 1'b0, '0, '0, 1'b0, "", 1'b0, '0);
   endtask

   task automatic sc(input logic [AW-1:0] a, input logic [IW-1:0] id, input bit ok, input string tag);
      step(1'b0, K_LOAD, '0, '0, 1'b1, a, id, ok, tag, 1'b0, '0);
   endtask

   task automatic inv(input logic [AW-1:0] a);
      step(1'b0, K_LOAD, '0, '0, 1'b0, '0, '0, 1'b0, "", 1'b1, a);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL R12 watchdog: got hang expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: outputs low while reset is held
      repeat (3) @(negedge clk);
      report("R1", "resp in reset", 64'(sc_resp_valid), 64'(0));
      report("R1", "fwd in reset", 64'(st_fwd_valid), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      report("R1", "resp after reset", 64'(sc_resp_valid), 64'(0));
      report("R1", "fwd after reset", 64'(st_fwd_valid), 64'(0));
      sc(32'h1000, 4'd1, 1'b0, "R1");

      // R2 / R5: reserve, succeed, then consumed
      cpl(K_LR, 32'h1000, 4'd1);
      sc(32'h1000, 4'd1, 1'b1, "R2");
      sc(32'h1000, 4'd1, 1'b0, "R5");

      // R3: foreign requester fails, owner still succeeds
      cpl(K_LR, 32'h2040, 4'd3);
      sc(32'h2040, 4'd5, 1'b0, "R3");
      sc(32'h2040, 4'd3, 1'b1, "R3");

      // R6: offsets ignored, full address forwarded
      cpl(K_LR, 32'h3007, 4'd2);
      sc(32'h303F, 4'd2, 1'b1, "R6");

      // R4: neighbouring line fails
      cpl(K_LR, 32'h4000, 4'd1);
      sc(32'h4040, 4'd1, 1'b0, "R4");
      sc(32'h4000, 4'd1, 1'b1, "R4");

      // R7: non-locked completions neither set nor disturb
      cpl(K_LR, 32'h5000, 4'd1);
      cpl(K_IFETCH, 32'h6000, 4'd2);
      cpl(K_LOAD, 32'h6000, 4'd2);
      cpl(K_STORE, 32'h6000, 4'd2);
      sc(32'h6000, 4'd2, 1'b0, "R7");
      sc(32'h5000, 4'd1, 1'b1, "R7");

      // R8: invalidate elsewhere keeps it, same line (with offset) clears it
      cpl(K_LR, 32'h7000, 4'd4);
      inv(32'h7100);
      sc(32'h7000, 4'd4, 1'b1, "R8");
      cpl(K_LR, 32'h7000, 4'd4);
      inv(32'h7020);
      sc(32'h7000, 4'd4, 1'b0, "R8");

      // R9: newer locked read replaces the older one
      cpl(K_LR, 32'h8000, 4'd1);
      cpl(K_LR, 32'h9000, 4'd2);
      sc(32'h8000, 4'd1, 1'b0, "R9");
      sc(32'h9000, 4'd2, 1'b1, "R9");

      // R10: failure code distinct from busy, checked via all failing cases above
      sc(32'hF000, 4'd7, 1'b0, "R10");

      // R11: same-edge completion installs after the query is judged
      cpl(K_LR, 32'hA000, 4'd1);
      step(1'b1, K_LR, 32'hB000, 4'd2, 1'b1, 32'hA000, 4'd1, 1'b1, "R11", 1'b0, '0);
      sc(32'hB000, 4'd2, 1'b1, "R11");
      // R11: same-edge invalidate does not defeat the query
      cpl(K_LR, 32'hC000, 4'd3);
      step(1'b0, K_LOAD, '0, '0, 1'b1, 32'hC000, 4'd3, 1'b1, "R11", 1'b1, 32'hC000);

      // R12: back-to-back queries each answered once
      cpl(K_LR, 32'hD000, 4'd6);
      sc(32'hD000, 4'd6, 1'b1, "R12");
      sc(32'hD000, 4'd6, 1'b0, "R12");
      sc(32'hE000, 4'd6, 1'b0, "R12");

      repeat (3) @(negedge clk);
      report("R12", "queue drained", 64'(sbq.size()), 64'(0));
      done = 1'b1;
      summary();
      $finish;
   end
endmodule